// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

A 16-bit up-counter peripheral with a small register interface. It counts one of two things. The first is an internal tick that fires once every four system clocks. The second is the rising edges of an external clock pin. The external pin is chosen from two inputs by a select bit. It passes through a ripple prescaler clocked by that pin, which divides by 1, 2, 4 or 8. The prescaler output then reaches the count either through a two-flop synchronizer with edge detection, or through a single-flop direct path. When the 16-bit count wraps from all ones to zero, a sticky interrupt flag is set.

A control state machine resolves the control bits and the sleep input into one operating mode per clock. It has five states:

- `M_OFF`: the run bit is clear.
- `M_INT`: internal tick.
- `M_EXT_SYNC`: synchronized external.
- `M_EXT_HELD`: synchronized external while sleep is asserted; counting is frozen.
- `M_EXT_DIRECT`: external, synchronizer bypassed.

Each clock the next state is chosen by priority:

1. run clear goes to `M_OFF`.
2. Otherwise, source clear goes to `M_INT`.
3. Otherwise, bypass set goes to `M_EXT_DIRECT`.
4. Otherwise, sleep set goes to `M_EXT_HELD`.
5. Otherwise, the state is `M_EXT_SYNC`.

So any state can move to any other state on the clock after its condition appears. The prescaler and the synchronizer keep running in every state. Only the increment enable depends on the state.

Software writes four byte addresses:

| Address | Contents |
|---|---|
| 0 | control |
| 1 | count low byte |
| 2 | count high byte |
| 3 | flag, bit 0 |

Reads use the same map, with unused bits returning zero.

Top module: `prescaled_timer16`

## Requirements
- R1: After reset the count, the control register (address 0) and the flag (address 3, bit 0) read as zero, and irq_o is low.
- R2: With control bit 0 (run) clear, the count does not change.
- R3: With run set and control bit 1 (source) clear, the count rises by one every 4 system clocks. Control bit 2 (sync bypass) has no effect in this mode.
- R4: With source set, the count follows rising edges of ext_pin_b when control bit 5 is 1 and of ext_pin_a when it is 0. Edges on the unselected pin are ignored.
- R5: Control bits [4:3] set the number of selected-pin rising edges per count: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R6: With bypass clear, the count changes on the third system clock rising edge after the prescaler output rises.
- R7: With bypass clear and sleep_i high, the count holds, while the prescaler keeps counting pin edges. Edges absorbed during sleep shift the phase of the first count after wake.
- R8: With bypass set, the count changes on the second system clock rising edge after the prescaler output rises, and it keeps counting while sleep_i is high.
- R9: An increment from 0xFFFF gives 0x0000, sets the flag and raises irq_o.
- R10: The flag stays set until a write to address 3 loads bit 0; writing 0 clears it. A wrap in the same cycle as that write wins.
- R11: A write to address 1 (low byte) or address 2 (high byte) shows on the next clock. It takes priority over an increment due in that cycle, and it leaves the prescaler phase untouched.
- R12: A write to address 0 stores bits [5:0] and reads back unchanged. The operating mode follows the control register and sleep_i one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep request; freezes synchronized external counting |
| ext_pin_a | input | 1 | External count input used when control bit 5 is 0 |
| ext_pin_b | input | 1 | External count input used when control bit 5 is 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 count low, 2 count high, 3 flag |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| irq_o | output | 1 | Overflow interrupt flag |

## Verification
The internal tick is run with the bypass bit both clear and set, which shows whether the bypass leaks into that mode. External pulses are sent to the selected pin and to the unselected pin, and each prescale setting is given a pulse train long enough to be phase-independent. Together these separate a wrong pin mux from a wrong tap choice. Single-edge timing in synchronized and bypass modes tells the two-stage path from the one-stage path. A sleep window absorbs a prescaler phase, which shows whether the prescaler froze along with the count. Presetting the count near 0xFFFF, and writing bytes while the timer runs, exercise the wrap, flag persistence and write priority.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int DATA_W     = 8;
    localparam int PS_FIELD_W = 2;
    localparam int CTRL_W     = 6;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_CNT_LO = 2'd1;
    localparam logic [1:0] A_CNT_HI = 2'd2;
    localparam logic [1:0] A_FLAG   = 2'd3;

    typedef enum logic [2:0] {
        M_OFF,
        M_INT,
        M_EXT_SYNC,
        M_EXT_HELD,
        M_EXT_DIRECT
    } mode_e;

    // bit 0 run, bit 1 source, bit 2 bypass, bits 4:3 prescale, bit 5 pin select
    typedef struct packed {
        logic                  pin_sel;
        logic [PS_FIELD_W-1:0] ps;
        logic                  bypass;
        logic                  src_ext;
        logic                  run;
    } ctrl_t;

endpackage

// File: rtl/ptmr_ripple_prescaler.sv
module ptmr_ripple_prescaler #(
    parameter int STAGES = 3,
    localparam int SEL_W = $clog2(STAGES + 1)
) (
    input  logic             ext_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             div_out
);

    logic [STAGES-1:0] q;
    logic [STAGES:0]   taps;

    // Each stage toggles on the falling edge of the one before it.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic bit_q;
        if (k == 0) begin : g_head
            always_ff @(posedge ext_clk or negedge rst_n) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= ~bit_q;
            end
        end else begin : g_tail
            always_ff @(negedge q[k-1] or negedge rst_n) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= ~bit_q;
            end
        end
        assign q[k] = bit_q;
    end

    assign taps    = {q, ext_clk};
    assign div_out = taps[sel];

endmodule

// File: rtl/ptmr_edge_sync.sv
module ptmr_edge_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic sync_rise,
    output logic fast_rise
);

    logic [DEPTH:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[DEPTH-1:0], d};
    end

    assign sync_rise = sh[DEPTH-1] & ~sh[DEPTH];
    assign fast_rise = sh[0] & ~sh[1];

endmodule

// File: rtl/ptmr_mode_fsm.sv
module ptmr_mode_fsm
    import ptmr_pkg::*;
#(
    parameter int TICK_DIV = 4,
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  src_ext,
    input  logic  bypass,
    input  logic  sleep_i,
    input  logic  sync_rise,
    input  logic  fast_rise,
    output mode_e mode_q,
    output logic  cnt_inc
);

    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             tick;
    mode_e            mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == DIV_LAST);

    always_comb begin
        if (!run)         mode_d = M_OFF;
        else if (!src_ext) mode_d = M_INT;
        else if (bypass)   mode_d = M_EXT_DIRECT;
        else if (sleep_i)  mode_d = M_EXT_HELD;
        else               mode_d = M_EXT_SYNC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_OFF;
        else        mode_q <= mode_d;
    end

    always_comb begin
        unique case (mode_q)
            M_OFF:        cnt_inc = 1'b0;
            M_INT:        cnt_inc = tick;
            M_EXT_SYNC:   cnt_inc = sync_rise;
            M_EXT_HELD:   cnt_inc = 1'b0;
            M_EXT_DIRECT: cnt_inc = fast_rise;
            default:      cnt_inc = 1'b0;
        endcase
    end

endmodule

// File: rtl/ptmr_count_regs.sv
module ptmr_count_regs #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_flag,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count_q,
    output logic              flag_q
);

    logic any_wr;
    logic wrap;

    assign any_wr = wr_lo | wr_hi;
    assign wrap   = inc & ~any_wr & (&count_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count_q <= '0;
        else if (wr_lo) count_q[BYTE_W-1:0] <= wr_data;
        else if (wr_hi) count_q[CNT_W-1:BYTE_W] <= wr_data;
        else if (inc)   count_q <= count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (wrap)    flag_q <= 1'b1;
        else if (wr_flag) flag_q <= wr_data[0];
    end

endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16
    import ptmr_pkg::*;
#(
    parameter int TICK_DIV   = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              ext_pin_a,
    input  logic              ext_pin_b,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);

    localparam int PS_STAGES = (1 << PS_FIELD_W) - 1;
    localparam int CNT_W     = 2 * DATA_W;

    ctrl_t            ctrl_q;
    mode_e            mode_q;
    logic             wr_lo, wr_hi, wr_flag, wr_ctrl;
    logic             ext_sel, presc_out;
    logic             sync_rise, fast_rise, cnt_inc;
    logic [CNT_W-1:0] count_q;
    logic             flag_q;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_lo   = wr_en && (wr_addr == A_CNT_LO);
    assign wr_hi   = wr_en && (wr_addr == A_CNT_HI);
    assign wr_flag = wr_en && (wr_addr == A_FLAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    assign ext_sel = ctrl_q.pin_sel ? ext_pin_b : ext_pin_a;

    ptmr_ripple_prescaler #(.STAGES(PS_STAGES)) u_presc (
        .ext_clk (ext_sel),
        .rst_n   (rst_n),
        .sel     (ctrl_q.ps),
        .div_out (presc_out)
    );

    ptmr_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .d         (presc_out),
        .sync_rise (sync_rise),
        .fast_rise (fast_rise)
    );

    ptmr_mode_fsm #(.TICK_DIV(TICK_DIV)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_q.run),
        .src_ext   (ctrl_q.src_ext),
        .bypass    (ctrl_q.bypass),
        .sleep_i   (sleep_i),
        .sync_rise (sync_rise),
        .fast_rise (fast_rise),
        .mode_q    (mode_q),
        .cnt_inc   (cnt_inc)
    );

    ptmr_count_regs #(.BYTE_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_flag (wr_flag),
        .wr_data (wr_data),
        .count_q (count_q),
        .flag_q  (flag_q)
    );

    always_comb begin
        unique case (rd_addr)
            A_CTRL:   rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            A_CNT_LO: rd_data = count_q[DATA_W-1:0];
            A_CNT_HI: rd_data = count_q[CNT_W-1:DATA_W];
            A_FLAG:   rd_data = {{(DATA_W-1){1'b0}}, flag_q};
            default:  rd_data = '0;
        endcase
    end

    assign irq_o = flag_q;

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
    import ptmr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input mode_e       mode,
    input logic        cnt_inc,
    input logic [15:0] count,
    input logic        flag,
    input logic        wr_lo,
    input logic        wr_hi,
    input logic        wr_flag,
    input logic [7:0]  wr_data,
    input ctrl_t       ctrl
);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == 16'h0000 && !flag));

    a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_OFF && !wr_lo && !wr_hi) |=> $stable(count));

    a_r7_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_EXT_HELD && !wr_lo && !wr_hi) |=> $stable(count));

    a_r9_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && count == 16'hFFFF && !wr_lo && !wr_hi) |=> (flag && count == 16'h0000));

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_flag) |=> flag);

    a_r11_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count[7:0] == $past(wr_data)));

    a_r12_off_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |=> (mode == M_OFF));

endmodule

bind prescaled_timer16 ptmr_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .cnt_inc (cnt_inc),
    .count   (count_q),
    .flag    (flag_q),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_flag (wr_flag),
    .wr_data (wr_data),
    .ctrl    (ctrl_q)
);

// File: tb/tb_prescaled_timer16.sv
module tb_prescaled_timer16;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam int MD_OFF = 0, MD_INT = 1, MD_SYNC = 2, MD_HELD = 3, MD_DIRECT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_i = 1'b0;
    logic       ext_pin_a = 1'b0;
    logic       ext_pin_b = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       irq_o;

    int    checks = 0;
    int    errors = 0;
    bit    running = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    logic [5:0]  m_ctrl = '0;
    logic [15:0] m_cnt = '0;
    logic        m_flag = 1'b0;
    int          m_mode = MD_OFF;
    int          m_div = 0;
    int          m_pcount = 0;
    logic        p1 = 0, p2 = 0, p3 = 0;
    logic        m_inc, m_wrap, m_psel;
    int          ratio;

    logic [7:0]  seen_ctrl;
    logic [15:0] seen_cnt;
    logic        seen_flag;

    wire bench_ext = m_ctrl[5] ? ext_pin_b : ext_pin_a;

    prescaled_timer16 dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_i   (sleep_i),
        .ext_pin_a (ext_pin_a),
        .ext_pin_b (ext_pin_b),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // Reference model: behavioural, updated on every rising clock.
    always @(posedge bench_ext or negedge rst_n) begin
        if (!rst_n) m_pcount = 0;
        else        m_pcount = m_pcount + 1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = '0; m_flag = 0; m_mode = MD_OFF; m_div = 0;
            p1 = 0; p2 = 0; p3 = 0;
        end else begin
            case (m_mode)
                MD_INT:    m_inc = (m_div == 3);
                MD_SYNC:   m_inc = p2 && !p3;
                MD_DIRECT: m_inc = p1 && !p2;
                default:   m_inc = 1'b0;
            endcase
            m_wrap = 1'b0;
            if (wr_en && wr_addr == 2'd1)      m_cnt = {m_cnt[15:8], wr_data};
            else if (wr_en && wr_addr == 2'd2) m_cnt = {wr_data, m_cnt[7:0]};
            else if (m_inc) begin
                if (m_cnt == 16'hFFFF) m_wrap = 1'b1;
                m_cnt = m_cnt + 16'd1;
            end
            if (m_wrap) m_flag = 1'b1;
            else if (wr_en && wr_addr == 2'd3) m_flag = wr_data[0];
            if (!m_ctrl[0])     m_mode = MD_OFF;
            else if (!m_ctrl[1]) m_mode = MD_INT;
            else if (m_ctrl[2])  m_mode = MD_DIRECT;
            else if (sleep_i)    m_mode = MD_HELD;
            else                 m_mode = MD_SYNC;
            ratio = int'(m_ctrl[4:3]);
            if (ratio == 0) m_psel = bench_ext;
            else            m_psel = ((m_pcount >> (ratio - 1)) & 1) != 0;
            p3 = p2; p2 = p1; p1 = m_psel;
            if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data[5:0];
            m_div = (m_div + 1) % 4;
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && running) begin
            rd_addr = 2'd0; #1 seen_ctrl = rd_data;
            rd_addr = 2'd1; #1 seen_cnt[7:0] = rd_data;
            rd_addr = 2'd2; #1 seen_cnt[15:8] = rd_data;
            rd_addr = 2'd3; #1 seen_flag = rd_data[0];
            chk("R12 control readback", int'(seen_ctrl), int'({2'b00, m_ctrl}));
            chk(cur_req, int'(seen_cnt), int'(m_cnt));
            chk(cur_req, int'(seen_flag), int'(m_flag));
            chk("R9 irq_o", int'(irq_o), int'(m_flag));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input bit use_b);
        @(negedge clk);
        if (use_b) ext_pin_b = 1'b1; else ext_pin_a = 1'b1;
        repeat (3) @(negedge clk);
        ext_pin_a = 1'b0; ext_pin_b = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic snap(output int v);
        @(posedge clk);
        v = int'(seen_cnt);
    endtask

    // Change control with run cleared first so a tap switch settles unseen.
    task automatic set_mode(input logic [7:0] c);
        wr(2'd0, c & 8'hFE);
        repeat (6) @(negedge clk);
        wr(2'd0, c);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            summary();
            $finish;
        end
    end

    initial begin
        int c0, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        repeat (2) @(posedge clk);
        // R1: reset values
        chk("R1 count", int'(seen_cnt), 0);
        chk("R1 control", int'(seen_ctrl), 0);
        chk("R1 flag", int'(seen_flag), 0);
        chk("R1 irq_o", int'(irq_o), 0);

        // R2: run clear, internal source
        cur_req = "R2";
        snap(c0);
        repeat (20) @(posedge clk);
        snap(c1);
        chk("R2 idle count", c1 - c0, 0);

        // R3: internal tick, bypass clear then set
        cur_req = "R3";
        set_mode(8'h01);
        snap(c0);
        repeat (40) @(posedge clk);
        c1 = int'(seen_cnt);
        chk("R3 tick/4", c1 - c0, 10);
        set_mode(8'h05);
        snap(c0);
        repeat (40) @(posedge clk);
        c1 = int'(seen_cnt);
        chk("R3 bypass ignored", c1 - c0, 10);

        // R11: byte writes while stopped
        cur_req = "R11";
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h12);
        snap(c0);
        chk("R11 byte write", c0, 16'h1234);

        // R4: pin selection
        cur_req = "R4";
        set_mode(8'h03);
        snap(c0);
        repeat (5) pulse(1'b0);
        snap(c1);
        chk("R4 pin_a counted", c1 - c0, 5);
        repeat (3) pulse(1'b1);
        snap(c0);
        chk("R4 pin_b ignored", c0 - c1, 0);
        set_mode(8'h23);
        snap(c0);
        repeat (4) pulse(1'b1);
        repeat (2) pulse(1'b0);
        snap(c1);
        chk("R4 pin_b counted", c1 - c0, 4);

        // R5: prescale ratios with 16 edges each
        cur_req = "R5";
        for (int ps = 1; ps < 4; ps++) begin
            set_mode(8'(8'h03 | (ps << 3)));
            snap(c0);
            repeat (16) pulse(1'b0);
            snap(c1);
            chk("R5 prescale", c1 - c0, 16 >> ps);
        end

        // R6: synchronized latency
        cur_req = "R6";
        set_mode(8'h03);
        @(negedge clk);
        ext_pin_a = 1'b1;
        snap(c0);
        @(posedge clk);
        @(posedge clk);
        chk("R6 not before third edge", int'(seen_cnt) - c0, 0);
        @(posedge clk);
        chk("R6 at third edge", int'(seen_cnt) - c0, 1);
        @(negedge clk);
        ext_pin_a = 1'b0;
        repeat (4) @(negedge clk);

        // R8: direct latency, counting during sleep
        cur_req = "R8";
        set_mode(8'h07);
        @(negedge clk);
        ext_pin_a = 1'b1;
        snap(c0);
        @(posedge clk);
        chk("R8 not before second edge", int'(seen_cnt) - c0, 0);
        @(posedge clk);
        chk("R8 at second edge", int'(seen_cnt) - c0, 1);
        @(negedge clk);
        ext_pin_a = 1'b0;
        sleep_i = 1'b1;
        repeat (3) @(negedge clk);
        snap(c0);
        repeat (3) pulse(1'b0);
        snap(c1);
        chk("R8 counts in sleep", c1 - c0, 3);
        @(negedge clk);
        sleep_i = 1'b0;

        // R7: sleep freezes synchronized count, prescaler keeps running
        cur_req = "R7";
        set_mode(8'h13);
        for (int i = 0; i < 8; i++) begin
            snap(c0);
            pulse(1'b0);
            snap(c1);
            if (c1 != c0) break;
        end
        @(negedge clk);
        sleep_i = 1'b1;
        repeat (2) @(negedge clk);
        snap(c0);
        repeat (6) pulse(1'b0);
        snap(c1);
        chk("R7 frozen in sleep", c1 - c0, 0);
        @(negedge clk);
        sleep_i = 1'b0;
        repeat (2) @(negedge clk);
        repeat (2) pulse(1'b0);
        snap(c1);
        chk("R7 prescaler kept phase", c1 - c0, 1);

        // R9 and R10: wrap and sticky flag
        cur_req = "R9";
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFE);
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h01);
        repeat (16) @(posedge clk);
        chk("R9 flag after wrap", int'(seen_flag), 1);
        chk("R9 irq_o after wrap", int'(irq_o), 1);
        chk("R9 count wrapped low", int'(seen_cnt < 16'd6), 1);
        cur_req = "R10";
        repeat (20) @(posedge clk);
        chk("R10 flag sticky", int'(seen_flag), 1);
        wr(2'd3, 8'h00);
        @(posedge clk);
        chk("R10 flag cleared", int'(seen_flag), 0);
        chk("R10 irq_o cleared", int'(irq_o), 0);

        // R11: low byte write wins while running
        cur_req = "R11";
        wr(2'd1, 8'h80);
        @(posedge clk);
        chk("R11 write wins", int'(seen_cnt[7:0]), 8'h80);
        wr(2'd0, 8'h00);
        repeat (4) @(posedge clk);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule